// File: doc/BRIEF.md
# Double-Buffered Converter Code Front End

This block is the digital input stage of a 12-bit digital-to-analog converter that sits on a microprocessor bus. A host writes the converter code as three 4-bit nibbles into a first rank of holding latches, in any order, one at a time or several at once. It then moves the assembled word into a second-rank 12-bit latch with a single strobe. Only the second rank drives the converter, so a partly written word never appears at the output.

Every storage element is level-sensitive. A latch is transparent while chip select and its own address line are both low. It closes and holds its value as soon as either of those lines goes high. Four active-low address lines each open one latch: three for the first-rank nibbles and one for the transfer into the second rank. The transfer latch reads the first-rank outputs, so when it is opened together with a nibble latch, bus data flows through both ranks. An active-low asynchronous reset clears every latch.

Top module: `dac_dbuf_front`

## Requirements
- R1: While rst_n is low, every latch clears to zero, so code reads 0. After release, a transfer with no nibbles loaded also yields 0.
- R2: sel_n[0] opens the low nibble latch, which takes din[3:0]. sel_n[1] opens the middle nibble latch, which takes din[7:4]. sel_n[2] opens the high nibble latch, which takes din[11:8].
- R3: sel_n[3] opens the transfer latch. It copies the three first-rank nibbles to code as {high, middle, low}. While this latch is closed, code does not change, whatever the first rank does.
- R4: While cs_n and a latch's address line are both low, that latch is transparent and its output follows its input.
- R5: A latch captures its input when either cs_n or its address line returns high, and holds that value afterwards, even if din changes.
- R6: While cs_n is high, no latch changes state for any value of sel_n or din.
- R7: Any combination of address lines may be low at the same time. Each opened nibble latch loads its own field. If the transfer latch is also open, the new data reaches code in the same access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of all latches |
| cs_n | input | 1 | Active-low chip select |
| sel_n | input | 4 | Active-low latch enables: [0] low, [1] middle, [2] high nibble, [3] transfer |
| din | input | 12 | Data bus |
| code | output | 12 | Second-rank converter code |

## Verification
Whenever any latch output changes, the embedded assertions check that the change occurred while that latch was open or under reset, that a reset change is to zero, and that code never moves while chip select is high. Each time a latch closes, they also check that it holds the value on its input. The mapping of bus fields to nibbles, load order, flow-through when several lines are low, and the invisibility of a half-written word at the output can only be shown by the bench. It sweeps every address pattern with chip select low and high, and after each access it reads the first rank back with a transfer to compare it against its own model.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned NUM_NIB = 3;
  localparam int unsigned WORD_W  = NIB_W * NUM_NIB;

  // Field i of a bus word (i = 0 is least significant).
  function automatic logic [NIB_W-1:0] field_of(input logic [WORD_W-1:0] w,
                                                input int unsigned i);
    return w[i*NIB_W +: NIB_W];
  endfunction

  // Active-low enable plus active-low select gives an active-high open.
  function automatic logic gate_open(input logic cs_n, input logic sel_n);
    return ~(cs_n | sel_n);
  endfunction
endpackage

// File: rtl/dac_strobe_decode.sv
module dac_strobe_decode #(
  parameter int unsigned N_LAT = 4
) (
  input  logic             cs_n,
  input  logic [N_LAT-1:0] sel_n,
  output logic [N_LAT-1:0] open
);
  import dac_dbuf_pkg::*;

  for (genvar g = 0; g < N_LAT; g++) begin : g_dec
    assign open[g] = gate_open(cs_n, sel_n[g]);
  end

  // R6
  always @(open)
    if (cs_n)
      cs_closed_chk: assert (open == '0)
        else $error("latch open while chip select is high");
endmodule

// File: rtl/dac_level_latch.sv
module dac_level_latch #(
  parameter int unsigned W = 4
) (
  input  logic         rst_n,
  input  logic         open,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (!rst_n)
      q <= '0;
    else if (open)
      q <= d;
  end

  // R5 / R3: the output moves only while the latch is open or under reset
  always @(q)
    if (rst_n)
      hold_chk: assert (open)
        else $error("latch output moved while closed");

  // R1
  always @(q)
    if (!rst_n)
      rst_zero_chk: assert (q == '0)
        else $error("latch not cleared by reset");

  // R5
  always @(negedge open)
    if (rst_n)
      capture_chk: assert (q == d)
        else $error("latch did not capture its input on close");
endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front #(
  parameter int unsigned NIB_W   = dac_dbuf_pkg::NIB_W,
  parameter int unsigned NUM_NIB = dac_dbuf_pkg::NUM_NIB
) (
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic [NUM_NIB:0]         sel_n,
  input  logic [NIB_W*NUM_NIB-1:0] din,
  output logic [NIB_W*NUM_NIB-1:0] code
);
  localparam int unsigned WW    = NIB_W * NUM_NIB;
  localparam int unsigned N_LAT = NUM_NIB + 1;
  localparam int unsigned XFER  = NUM_NIB;

  logic [N_LAT-1:0] open;
  logic [WW-1:0]    rank1_word;

  dac_strobe_decode #(.N_LAT(N_LAT)) u_dec (
    .cs_n  (cs_n),
    .sel_n (sel_n),
    .open  (open)
  );

  for (genvar g = 0; g < NUM_NIB; g++) begin : g_rank1
    dac_level_latch #(.W(NIB_W)) u_nib (
      .rst_n (rst_n),
      .open  (open[g]),
      .d     (din[g*NIB_W +: NIB_W]),
      .q     (rank1_word[g*NIB_W +: NIB_W])
    );
  end

  dac_level_latch #(.W(WW)) u_rank2 (
    .rst_n (rst_n),
    .open  (open[XFER]),
    .d     (rank1_word),
    .q     (code)
  );

  // R6
  always @(code)
    if (rst_n)
      cs_guard_chk: assert (!cs_n)
        else $error("code changed while chip select high");

  // R3
  always @(code)
    if (rst_n)
      xfer_only_chk: assert (!sel_n[XFER])
        else $error("code changed without transfer strobe");
endmodule

// File: tb/dac_dbuf_front_tb.sv
module dac_dbuf_front_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        cs_n;
  logic [3:0]  sel_n;
  logic [11:0] din;
  logic [11:0] code;

  dac_dbuf_front u_dut (
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sel_n (sel_n),
    .din   (din),
    .code  (code)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0]  m_nib [3];
  logic [11:0] m_code;

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: code=%03h expected=%03h", req, got, exp);
    end
  endtask

  function automatic logic [11:0] model_word();
    return {m_nib[2], m_nib[1], m_nib[0]};
  endfunction

  // One access: data, then address, then chip select; release in the given order.
  task automatic access(input logic csn, input logic [3:0] s, input logic [11:0] d,
                        input bit cs_first, input string req);
    @(negedge clk) din = d;
    @(negedge clk) sel_n = s;
    @(negedge clk) cs_n = csn;
    if (!csn) begin
      for (int i = 0; i < 3; i++) if (!s[i]) m_nib[i] = d[i*4 +: 4];
      if (!s[3]) m_code = model_word();
    end
    @(posedge clk) check({req, " transparent R4"}, code, m_code);
    @(negedge clk) if (cs_first) cs_n = 1'b1; else sel_n = 4'hF;
    @(negedge clk) begin cs_n = 1'b1; sel_n = 4'hF; end
    @(negedge clk) din = ~d;
    @(posedge clk) check({req, " hold R5"}, code, m_code);
  endtask

  task automatic readback(input string req);
    access(1'b0, 4'b0111, 12'h000, 1'b0, req);
    check({req, " readback R3"}, code, model_word());
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: code=%03h expected=%03h", code, m_code);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sel_n = 4'hF; din = 12'hABC;
    for (int i = 0; i < 3; i++) m_nib[i] = 4'h0;
    m_code = 12'h000;
    repeat (3) @(negedge clk);
    check("R1 reset", code, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    readback("R1 cleared rank1");

    // R2 single nibbles in arbitrary order, code unchanged until transfer (R3)
    access(1'b0, 4'b1011, 12'h3C5, 1'b1, "R2 high");
    check("R3 no xfer", code, 12'h000);
    access(1'b0, 4'b1110, 12'h7A9, 1'b0, "R2 low");
    check("R3 no xfer", code, 12'h000);
    access(1'b0, 4'b1101, 12'hE42, 1'b1, "R2 mid");
    check("R3 no xfer", code, 12'h000);
    access(1'b0, 4'b0111, 12'hFFF, 1'b0, "R3 xfer");
    check("R2 assembled", code, 12'h349);

    // R4 transparency with flow-through, din changing while open
    @(negedge clk) begin din = 12'h111; sel_n = 4'b0000; end
    @(negedge clk) cs_n = 1'b0;
    @(posedge clk) check("R4 follow a", code, 12'h111);
    @(negedge clk) din = 12'h5D6;
    @(posedge clk) check("R4 follow b", code, 12'h5D6);
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk) din = 12'h000;
    @(posedge clk) check("R5 held", code, 12'h5D6);
    @(negedge clk) sel_n = 4'hF;
    for (int i = 0; i < 3; i++) m_nib[i] = 12'h5D6 >> (4 * i);
    m_code = 12'h5D6;

    // R6 / R7 sweep of every address pattern, chip select high then low
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 16; s++) begin
        logic [11:0] d;
        d = 12'((s * 12'h9E3 + c * 12'h2B7 + 12'h5A1) & 12'hFFF);
        access(c == 0, 4'(s), d, s[0], c == 0 ? "R6 cs high" : "R7 combo");
        readback(c == 0 ? "R6 rank1" : "R7 rank1");
      end
    end

    // R1 reset in mid-operation
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk) check("R1 async clear", code, 12'h000);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 3; i++) m_nib[i] = 4'h0;
    m_code = 12'h000;
    readback("R1 rank1 clear");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule